// File: doc/BRIEF.md
# Connection Mask Rewiring Unit

This block maintains the binary fan-in mask of one hypercolumn. There are N candidate incoming connections, and the number of live ones must stay the same from pass to pass. A controller pulses `start`. It then streams one unsigned fitness score per connection in ascending index order, each with that connection's present mask bit, over a valid/ready handshake. The last beat is marked with `s_last`.

While the stream runs, the unit tracks two connections:
- the live connection with the poorest score;
- the dormant connection with the best score.

Once the stream ends, it trades their states. It does this only when the trade is a strict improvement and rewiring is enabled. It then publishes the new mask, the two affected indices and a one-cycle `done` pulse. A pass whose beat count differs from N is flagged and leaves the mask untouched. Score computation lies outside this block.

Top module: `mask_rewire_unit`

## Requirements
- R1: After reset, `mask_o` is all zero, and `done`, `swapped`, `err` and `s_ready` are low. `s_ready` is high only from the cycle after `start` until the beat carrying `s_last` is accepted. Each `start` discards the tracking results of any earlier pass.
- R2: Among beats whose mask bit is 1, the one with the smallest score is chosen for silencing. On equal scores the lowest index wins. Its index appears on `sil_idx` with `done`.
- R3: Among beats whose mask bit is 0, the one with the largest score is chosen for activation. On equal scores the lowest index wins. Its index appears on `act_idx` with `done`.
- R4: The trade happens only when the chosen dormant score is strictly greater than the chosen live score. In that case `mask_o` equals the streamed mask with the `sil_idx` bit cleared and the `act_idx` bit set, and `swapped` is 1. Otherwise `mask_o` equals the streamed mask and `swapped` is 0.
- R5: If every streamed bit is 1, or every streamed bit is 0, the pass ends with `swapped` = 0 and the mask equal to the streamed mask.
- R6: With `rw_en` low, a pass completes normally but never trades: `swapped` is 0 and `mask_o` equals the streamed mask.
- R7: If the number of accepted beats up to and including `s_last` is not N, then `err` is 1 with `done`, `swapped` is 0, and `mask_o` keeps its value from before the pass. Beats past index N-1 are not stored.
- R8: `done` is high for exactly one cycle. It is visible in the second cycle after the clock edge that accepts the last beat. A successful pass never changes the number of ones in the mask relative to the streamed mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rw_en | input | 1 | Rewiring enable; low bypasses the trade |
| start | input | 1 | Begins a pass when the unit is idle |
| s_valid | input | 1 | Score beat valid |
| s_ready | output | 1 | Unit accepts a score beat |
| s_score | input | SCORE_W | Unsigned score of the current connection |
| s_mask | input | 1 | Present mask bit of the current connection |
| s_last | input | 1 | Marks the final beat of the pass |
| done | output | 1 | One-cycle pass completion pulse |
| swapped | output | 1 | A trade was made in the finished pass |
| err | output | 1 | Beat count of the finished pass differed from N |
| sil_idx | output | IDX_W | Index chosen for silencing |
| act_idx | output | IDX_W | Index chosen for activation |
| mask_o | output | N | Connectivity mask after the last pass |

## Verification
The minimum search and the maximum search run on the same beats. The final decision also combines the gain test with the enable input and the count check in a single cycle. The vector table therefore covers several cases:
- live and dormant candidates with tied scores;
- a dormant score equal to the live score, which must not trade;
- a lone live connection at the top index;
- the same data with rewiring disabled.

Each result is judged against a mask computed by hand for the `done` cycle. Short and long passes check that the count fault takes priority over an otherwise valid trade.

// File: rtl/mru_pkg.sv
package mru_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mru_state_e;

    // Strict comparison keeps the earliest candidate on ties.
    function automatic logic mru_beats(input logic want_max,
                                       input logic a_gt_b,
                                       input logic a_lt_b);
        return want_max ? a_gt_b : a_lt_b;
    endfunction

endpackage

// File: rtl/mru_tracker.sv
module mru_tracker #(
    parameter int SCORE_W  = 8,
    parameter int IDX_W    = 3,
    parameter bit WANT_MAX = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               in_vld,
    input  logic [SCORE_W-1:0] in_score,
    input  logic [IDX_W-1:0]   in_idx,
    output logic               best_vld,
    output logic [SCORE_W-1:0] best_score,
    output logic [IDX_W-1:0]   best_idx
);
    import mru_pkg::*;

    logic take;

    always_comb begin
        take = in_vld && (!best_vld ||
               mru_beats(WANT_MAX, in_score > best_score, in_score < best_score));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_vld   <= 1'b0;
            best_score <= '0;
            best_idx   <= '0;
        end else if (take) begin
            best_vld   <= 1'b1;
            best_score <= in_score;
            best_idx   <= in_idx;
        end
    end

endmodule

// File: rtl/mru_ctrl.sv
module mru_ctrl #(
    parameter int N    = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             beat,
    output logic             clr,
    output logic             fin,
    output logic             bad_cnt,
    output logic [CNT_W-1:0] cnt
);
    import mru_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(N);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N - 1);

    mru_state_e st;

    assign s_ready = (st == ST_RUN);
    assign beat    = s_ready && s_valid;
    assign clr     = (st == ST_IDLE) && start;
    assign fin     = (st == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            bad_cnt <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_RUN;
                    cnt     <= '0;
                    bad_cnt <= 1'b0;
                end
                ST_RUN: if (beat) begin
                    if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                    if (s_last) begin
                        st      <= ST_FIN;
                        bad_cnt <= (cnt != CNT_LAST);
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: the stream is closed in the cycle after its final beat
    a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (beat && s_last) |=> !s_ready);

endmodule

// File: rtl/mask_rewire_unit.sv
module mask_rewire_unit #(
    parameter int N       = 8,
    parameter int SCORE_W = 8,
    parameter int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rw_en,
    input  logic               start,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [SCORE_W-1:0] s_score,
    input  logic               s_mask,
    input  logic               s_last,
    output logic               done,
    output logic               swapped,
    output logic               err,
    output logic [IDX_W-1:0]   sil_idx,
    output logic [IDX_W-1:0]   act_idx,
    output logic [N-1:0]       mask_o
);
    localparam int CNT_W = $clog2(N + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(N);

    logic             beat, clr, fin, bad_cnt;
    logic [CNT_W-1:0] cnt;
    logic             in_range;
    logic [N-1:0]     mask_s, mask_trade;

    logic               t_vld   [2];
    logic [SCORE_W-1:0] t_score [2];
    logic [IDX_W-1:0]   t_idx   [2];

    mru_ctrl #(.N(N), .CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .s_valid(s_valid),
        .s_last(s_last), .s_ready(s_ready), .beat(beat), .clr(clr),
        .fin(fin), .bad_cnt(bad_cnt), .cnt(cnt)
    );

    assign in_range = (cnt < CNT_MAX);

    // Index 0 tracks the weakest live link, index 1 the strongest dormant one.
    for (genvar g = 0; g < 2; g++) begin : g_trk
        mru_tracker #(.SCORE_W(SCORE_W), .IDX_W(IDX_W), .WANT_MAX(g == 1)) trk_i (
            .clk(clk), .rst(rst), .clr(clr),
            .in_vld(beat && in_range && (s_mask == (g == 0))),
            .in_score(s_score), .in_idx(cnt[IDX_W-1:0]),
            .best_vld(t_vld[g]), .best_score(t_score[g]), .best_idx(t_idx[g])
        );
    end

    logic do_trade;
    always_comb begin
        do_trade   = rw_en && t_vld[0] && t_vld[1] && (t_score[1] > t_score[0]);
        mask_trade = mask_s;
        mask_trade[t_idx[0]] = 1'b0;
        mask_trade[t_idx[1]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_s  <= '0;
            mask_o  <= '0;
            done    <= 1'b0;
            swapped <= 1'b0;
            err     <= 1'b0;
            sil_idx <= '0;
            act_idx <= '0;
        end else begin
            done <= fin;
            if (beat && in_range) mask_s[cnt[IDX_W-1:0]] <= s_mask;
            if (fin) begin
                err     <= bad_cnt;
                sil_idx <= t_idx[0];
                act_idx <= t_idx[1];
                swapped <= !bad_cnt && do_trade;
                if (!bad_cnt) mask_o <= do_trade ? mask_trade : mask_s;
            end
        end
    end

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: a good pass keeps the number of live links
    a_r8_fanin_kept: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> ($countones(mask_o) == $countones(mask_s)));
    // R4: a trade moves exactly the two reported bits
    a_r4_trade_bits: assert property (@(posedge clk) disable iff (rst)
        (done && swapped) |-> (mask_s[sil_idx] && !mask_s[act_idx] &&
                               !mask_o[sil_idx] && mask_o[act_idx]));
    // R4: without a trade the streamed mask is published as is
    a_r4_no_trade_copy: assert property (@(posedge clk) disable iff (rst)
        (done && !swapped && !err) |-> (mask_o == mask_s));
    // R7: a miscounted pass leaves the mask alone
    a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!swapped && mask_o == $past(mask_o)));

endmodule

// File: tb/mask_rewire_unit_tb_top.sv
module mask_rewire_unit_tb_top;
    localparam int N = 8;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst, rw_en, start, s_valid, s_mask, s_last;
    logic [SW-1:0] s_score;
    logic s_ready, done, swapped, err;
    logic [2:0] sil_idx, act_idx;
    logic [N-1:0] mask_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    mask_rewire_unit #(.N(N), .SCORE_W(SW)) dut_i (
        .clk(clk), .rst(rst), .rw_en(rw_en), .start(start),
        .s_valid(s_valid), .s_ready(s_ready), .s_score(s_score),
        .s_mask(s_mask), .s_last(s_last), .done(done), .swapped(swapped),
        .err(err), .sil_idx(sil_idx), .act_idx(act_idx), .mask_o(mask_o)
    );

    typedef struct packed {
        logic [63:0] sc;
        logic [7:0]  m;
        logic        en;
        logic [7:0]  em;
        logic        esw;
        logic [2:0]  es;
        logic [2:0]  ea;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{64'h0128_0728_1E05_140A, 8'h0F, 1'b1, 8'h1B, 1'b1, 3'd2, 3'd4}, // R2 R3 R4, silent tie
        '{64'h321E_140A_5046_3C32, 8'h0F, 1'b1, 8'h0F, 1'b0, 3'd0, 3'd0}, // R4 equal, no trade
        '{64'h0102_0304_0506_0708, 8'hFF, 1'b1, 8'hFF, 1'b0, 3'd0, 3'd0}, // R5 all live
        '{64'h0102_0304_0506_0708, 8'h00, 1'b1, 8'h00, 1'b0, 3'd0, 3'd0}, // R5 all dormant
        '{64'h03C8_0809_0309_0309, 8'hAA, 1'b1, 8'hE8, 1'b1, 3'd1, 3'd6}, // R2 live tie
        '{64'h0128_0728_1E05_140A, 8'h0F, 1'b0, 8'h0F, 1'b0, 3'd0, 3'd0}, // R6 bypass
        '{64'h0007_0605_0403_0201, 8'h80, 1'b1, 8'h40, 1'b1, 3'd7, 3'd6}  // R4 top index
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Runs a pass of nb beats; returns at the negedge where done should be high.
    task automatic run_pass(input logic [63:0] sc, input logic [7:0] m, input int nb);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R1 ready in pass", 32'(s_ready), 32'd1);
        for (int i = 0; i < nb; i++) begin
            s_valid = 1'b1;
            s_score = sc[8*(i%8) +: 8];
            s_mask  = m[i%8];
            s_last  = (i == nb - 1);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
        check("R1 ready after last", 32'(s_ready), 32'd0);
        check("R8 done not early", 32'(done), 32'd0);
        @(negedge clk);
        check("R8 done timing", 32'(done), 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; rw_en = 1'b1; start = 1'b0; s_valid = 1'b0;
        s_mask = 1'b0; s_last = 1'b0; s_score = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset mask", 32'(mask_o), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset ready", 32'(s_ready), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle ready", 32'(s_ready), 32'd0);

        for (int v = 0; v < 7; v++) begin
            rw_en = VEC[v].en;
            run_pass(VEC[v].sc, VEC[v].m, N);
            check("R4 R5 R6 mask", 32'(mask_o), 32'(VEC[v].em));
            check("R4 swapped", 32'(swapped), 32'(VEC[v].esw));
            check("R7 err clear", 32'(err), 32'd0);
            if (VEC[v].esw) begin
                check("R2 sil_idx", 32'(sil_idx), 32'(VEC[v].es));
                check("R3 act_idx", 32'(act_idx), 32'(VEC[v].ea));
            end
            @(negedge clk);
            check("R8 done one cycle", 32'(done), 32'd0);
        end
        rw_en = 1'b1;

        // R7: short pass, would otherwise trade
        run_pass(VEC[0].sc, VEC[0].m, N - 1);
        check("R7 short err", 32'(err), 32'd1);
        check("R7 short swapped", 32'(swapped), 32'd0);
        check("R7 short mask held", 32'(mask_o), 32'h40);

        // R7: long pass
        run_pass(VEC[0].sc, VEC[0].m, N + 1);
        check("R7 long err", 32'(err), 32'd1);
        check("R7 long mask held", 32'(mask_o), 32'h40);

        // R1: a new start discards stale results
        run_pass(VEC[4].sc, VEC[4].m, N);
        check("R1 fresh pass mask", 32'(mask_o), 32'hE8);
        check("R1 fresh pass err", 32'(err), 32'd0);
        check("R2 fresh sil", 32'(sil_idx), 32'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule